// File: doc/BRIEF.md
# Request/Acknowledge Clock-Domain Bridge

This block moves a single bus transaction from a host clock domain into an unrelated system clock domain and returns a completion with a 32-bit response word. The host raises a request for one host clock together with a 48-bit packed word. The word carries two command flags, a 14-bit word address and a 32-bit write value. The bridge holds that word and signals the request across with a toggle level that passes through a synchronizer. In the system domain it fires exactly one write or read strobe. A toggle comes back the same way, and the host sees a one-cycle acknowledge together with the response word.

The host may wait as long as the system side needs. Nothing times out, and a request stays pending until the system side has serviced it. A second request that arrives while one is still in flight is dropped, and the pending transfer is left untouched. A write also returns a response word. Its content carries no meaning and the host discards it.

Top module: `xclk_txn_bridge`

## Requirements
- R1: A request word with bit 47 set is a write. It produces one `sysWrEn` pulse with `sysAddr` equal to bits 45:32 and `sysWrData` equal to bits 31:0, where bits 31:16 form the upper half and bits 15:0 the lower half.
- R2: A request word with bit 46 set and bit 47 clear is a read. It produces one `sysRdEn` pulse with `sysAddr` equal to bits 45:32. `sysRdData` is sampled one system clock after the strobe and is returned on `hostResp`.
- R3: Each accepted request raises its system strobe for exactly one system clock cycle, and only once.
- R4: `hostAck` is high for exactly one host clock per accepted request. `hostResp` takes its new value in that same cycle and holds it until the next acknowledge.
- R5: The request word is captured in the cycle `hostReq` is high. Later changes on `hostPayload` do not affect the transfer in flight.
- R6: A `hostReq` pulse that arrives while a transfer is outstanding is ignored. It causes no extra strobe and no extra acknowledge, and it does not alter the address or response of the pending transfer.
- R7: A read leaves `sysWrData` unchanged. The write-data field of a read request is never driven out.
- R8: When both flags are set, the request is handled as a write only. When neither flag is set, no strobe fires, but the acknowledge still returns.
- R9: There is no timeout. If the system clock stalls, no acknowledge appears. Once the clock resumes, the pending request completes with correct data.
- R10: After reset, `hostAck`, `sysWrEn` and `sysRdEn` are low, and `hostResp`, `sysAddr` and `sysWrData` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hostClk | input | 1 | Host domain clock |
| hostRstN | input | 1 | Host domain asynchronous reset, active low |
| hostReq | input | 1 | One-cycle request pulse |
| hostPayload | input | 48 | Packed request: write flag, read flag, address, write data |
| hostAck | output | 1 | One-cycle completion pulse |
| hostResp | output | 32 | Response word, valid from hostAck onwards |
| sysClk | input | 1 | System domain clock |
| sysRstN | input | 1 | System domain asynchronous reset, active low |
| sysAddr | output | 14 | Word address to the system side |
| sysWrEn | output | 1 | One-cycle write strobe |
| sysWrData | output | 32 | Write value to the system side |
| sysRdEn | output | 1 | One-cycle read strobe |
| sysRdData | input | 32 | Read data, valid one system clock after sysRdEn |

## Verification
The bench builds the bridge with its default parameters: a 14-bit address, a 32-bit data word and a two-stage synchronizer. This makes the flag positions at bits 47 and 46 directly observable, along with the all-ones address at the top of the field. With two stages, a round trip takes only a handful of cycles, so the bench can also stop the system clock for hundreds of host cycles and prove that nothing is dropped. The two clock periods are unrelated (20 ns and 13 ns), so the toggles cross at shifting phases from one transfer to the next.

// File: rtl/bridge_pkg.sv
`timescale 1ns / 1ps
package bridge_pkg;

  // Strobes from the handshake control to the datapath registers.
  typedef struct packed {
    logic hostCapture;   // host domain: latch the request word
    logic hostRespLoad;  // host domain: take the response word
    logic sysLaunch;     // system domain: drive address and strobe
    logic sysRdCapture;  // system domain: sample read data
  } bridgeStrobes_t;

endpackage

// File: rtl/bridge_sync.sv
`timescale 1ns / 1ps
module bridge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  generate
    if (STAGES > 1) begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end else begin : g_single
      logic stage;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= 1'b0;
        else       stage <= d;
      end
      assign q = stage;
    end
  endgenerate

endmodule

// File: rtl/bridge_ctrl.sv
`timescale 1ns / 1ps
module bridge_ctrl
  import bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           hostClk,
  input  logic           hostRstN,
  input  logic           hostReq,
  output logic           hostAck,
  output logic           hostBusy,
  input  logic           sysClk,
  input  logic           sysRstN,
  output bridgeStrobes_t stb
);

  // Host domain state
  logic reqTog;
  logic ackSeen;
  logic ackPrev;
  logic accept;
  logic ackEdge;

  // System domain state
  logic ackTog;
  logic reqSeen;
  logic reqPrev;
  logic launch;
  logic phaseA;
  logic phaseB;

  assign accept  = hostReq && !hostBusy;
  assign ackEdge = ackSeen ^ ackPrev;

  always_ff @(posedge hostClk or negedge hostRstN) begin
    if (!hostRstN) begin
      reqTog   <= 1'b0;
      hostBusy <= 1'b0;
      ackPrev  <= 1'b0;
      hostAck  <= 1'b0;
    end else begin
      ackPrev <= ackSeen;
      hostAck <= ackEdge;
      if (accept) begin
        reqTog   <= ~reqTog;
        hostBusy <= 1'b1;
      end else if (ackEdge) begin
        hostBusy <= 1'b0;
      end
    end
  end

  bridge_sync #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk  (sysClk),
    .rstN (sysRstN),
    .d    (reqTog),
    .q    (reqSeen)
  );

  assign launch = reqSeen ^ reqPrev;

  // launch -> strobe cycle (phaseA) -> data-return cycle (phaseB) -> capture
  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      reqPrev <= 1'b0;
      phaseA  <= 1'b0;
      phaseB  <= 1'b0;
      ackTog  <= 1'b0;
    end else begin
      reqPrev <= reqSeen;
      phaseA  <= launch;
      phaseB  <= phaseA;
      if (phaseB) ackTog <= ~ackTog;
    end
  end

  bridge_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk  (hostClk),
    .rstN (hostRstN),
    .d    (ackTog),
    .q    (ackSeen)
  );

  always_comb begin
    stb.hostCapture  = accept;
    stb.hostRespLoad = ackEdge;
    stb.sysLaunch    = launch;
    stb.sysRdCapture = phaseB;
  end

endmodule

// File: rtl/bridge_datapath.sv
`timescale 1ns / 1ps
module bridge_datapath
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  localparam int PAY_W = 2 + ADDR_W + DATA_W
) (
  input  logic              hostClk,
  input  logic              hostRstN,
  input  logic              sysClk,
  input  logic              sysRstN,
  input  bridgeStrobes_t    stb,
  input  logic [PAY_W-1:0]  hostPayload,
  output logic [PAY_W-1:0]  heldPayload,
  output logic [DATA_W-1:0] hostResp,
  output logic [ADDR_W-1:0] sysAddr,
  output logic              sysWrEn,
  output logic              sysRdEn,
  output logic [DATA_W-1:0] sysWrData,
  input  logic [DATA_W-1:0] sysRdData
);

  localparam int WR_BIT = PAY_W - 1;
  localparam int RD_BIT = PAY_W - 2;

  logic              wrFlag;
  logic              rdOnly;
  logic [ADDR_W-1:0] addrField;
  logic [DATA_W-1:0] dataField;
  logic              readPend;
  logic [DATA_W-1:0] sysResp;

  assign wrFlag    = heldPayload[WR_BIT];
  assign rdOnly    = heldPayload[RD_BIT] && !wrFlag;
  assign addrField = heldPayload[DATA_W +: ADDR_W];
  assign dataField = heldPayload[DATA_W-1:0];

  always_ff @(posedge hostClk or negedge hostRstN) begin
    if (!hostRstN) begin
      heldPayload <= '0;
      hostResp    <= '0;
    end else begin
      if (stb.hostCapture)  heldPayload <= hostPayload;
      if (stb.hostRespLoad) hostResp    <= sysResp;
    end
  end

  // The held word is read here only after the synchronized toggle arrives.
  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      sysAddr   <= '0;
      sysWrEn   <= 1'b0;
      sysRdEn   <= 1'b0;
      sysWrData <= '0;
      readPend  <= 1'b0;
      sysResp   <= '0;
    end else begin
      sysWrEn <= stb.sysLaunch && wrFlag;
      sysRdEn <= stb.sysLaunch && rdOnly;
      if (stb.sysLaunch) begin
        sysAddr  <= addrField;
        readPend <= rdOnly;
        if (wrFlag) sysWrData <= dataField;
      end
      if (stb.sysRdCapture && readPend) sysResp <= sysRdData;
    end
  end

endmodule

// File: rtl/xclk_txn_bridge.sv
`timescale 1ns / 1ps
module xclk_txn_bridge
  import bridge_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int PAY_W      = 2 + ADDR_W + DATA_W
) (
  input  logic              hostClk,
  input  logic              hostRstN,
  input  logic              hostReq,
  input  logic [PAY_W-1:0]  hostPayload,
  output logic              hostAck,
  output logic [DATA_W-1:0] hostResp,
  input  logic              sysClk,
  input  logic              sysRstN,
  output logic [ADDR_W-1:0] sysAddr,
  output logic              sysWrEn,
  output logic [DATA_W-1:0] sysWrData,
  output logic              sysRdEn,
  input  logic [DATA_W-1:0] sysRdData
);

  bridgeStrobes_t    stb;
  logic              hostBusy;
  logic [PAY_W-1:0]  heldPayload;

  bridge_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .hostClk  (hostClk),
    .hostRstN (hostRstN),
    .hostReq  (hostReq),
    .hostAck  (hostAck),
    .hostBusy (hostBusy),
    .sysClk   (sysClk),
    .sysRstN  (sysRstN),
    .stb      (stb)
  );

  bridge_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .hostClk     (hostClk),
    .hostRstN    (hostRstN),
    .sysClk      (sysClk),
    .sysRstN     (sysRstN),
    .stb         (stb),
    .hostPayload (hostPayload),
    .heldPayload (heldPayload),
    .hostResp    (hostResp),
    .sysAddr     (sysAddr),
    .sysWrEn     (sysWrEn),
    .sysRdEn     (sysRdEn),
    .sysWrData   (sysWrData),
    .sysRdData   (sysRdData)
  );

endmodule

// File: rtl/bridge_checks.sv
`timescale 1ns / 1ps
module bridge_checks #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  localparam int PAY_W = 2 + ADDR_W + DATA_W
) (
  input logic              hostClk,
  input logic              hostRstN,
  input logic              sysClk,
  input logic              sysRstN,
  input logic              hostAck,
  input logic [DATA_W-1:0] hostResp,
  input logic              hostBusy,
  input logic [PAY_W-1:0]  heldPayload,
  input logic              sysWrEn,
  input logic              sysRdEn,
  input logic [DATA_W-1:0] sysWrData
);

  p_wr_single_r3: assert property (@(posedge sysClk) disable iff (!sysRstN)
    sysWrEn |=> !sysWrEn);

  p_rd_single_r3: assert property (@(posedge sysClk) disable iff (!sysRstN)
    sysRdEn |=> !sysRdEn);

  p_one_strobe_r8: assert property (@(posedge sysClk) disable iff (!sysRstN)
    !(sysWrEn && sysRdEn));

  p_wrdata_moves_on_write_r7: assert property (@(posedge sysClk) disable iff (!sysRstN)
    !$stable(sysWrData) |-> sysWrEn);

  p_ack_single_r4: assert property (@(posedge hostClk) disable iff (!hostRstN)
    hostAck |=> !hostAck);

  p_resp_hold_r4: assert property (@(posedge hostClk) disable iff (!hostRstN)
    !hostAck |-> $stable(hostResp));

  p_held_stable_r5: assert property (@(posedge hostClk) disable iff (!hostRstN)
    $past(hostBusy) |-> $stable(heldPayload));

  p_ack_ends_busy_r6: assert property (@(posedge hostClk) disable iff (!hostRstN)
    hostAck |-> ($past(hostBusy) && !hostBusy));

endmodule

bind xclk_txn_bridge bridge_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checks (
  .hostClk     (hostClk),
  .hostRstN    (hostRstN),
  .sysClk      (sysClk),
  .sysRstN     (sysRstN),
  .hostAck     (hostAck),
  .hostResp    (hostResp),
  .hostBusy    (hostBusy),
  .heldPayload (heldPayload),
  .sysWrEn     (sysWrEn),
  .sysRdEn     (sysRdEn),
  .sysWrData   (sysWrData)
);

// File: tb/xclk_txn_bridge_tb.sv
`timescale 1ns / 1ps
module xclk_txn_bridge_tb;

  logic        hostClk = 1'b0;
  logic        sysClk  = 1'b0;
  logic        sysClkEn = 1'b1;
  logic        hostRstN = 1'b0;
  logic        sysRstN  = 1'b0;
  logic        hostReq = 1'b0;
  logic [47:0] hostPayload = '0;
  logic        hostAck;
  logic [31:0] hostResp;
  logic [13:0] sysAddr;
  logic        sysWrEn;
  logic [31:0] sysWrData;
  logic        sysRdEn;
  logic [31:0] sysRdData = '0;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  int wrCnt = 0, rdCnt = 0, ackTotal = 0;
  int wrRun = 0, rdRun = 0, maxRun = 0;
  logic [13:0] lastWrAddr = '0, lastRdAddr = '0;
  logic [31:0] lastWrData = '0;

  xclk_txn_bridge u_dut (
    .hostClk     (hostClk),
    .hostRstN    (hostRstN),
    .hostReq     (hostReq),
    .hostPayload (hostPayload),
    .hostAck     (hostAck),
    .hostResp    (hostResp),
    .sysClk      (sysClk),
    .sysRstN     (sysRstN),
    .sysAddr     (sysAddr),
    .sysWrEn     (sysWrEn),
    .sysWrData   (sysWrData),
    .sysRdEn     (sysRdEn),
    .sysRdData   (sysRdData)
  );

  always #10 hostClk = ~hostClk;
  initial forever begin
    #6.5;
    if (sysClkEn) sysClk = ~sysClk;
  end

  function automatic logic [31:0] memf(input logic [13:0] a);
    return {a, 2'b10, ~a, 2'b01};
  endfunction

  // Read responder: data appears one system clock after the strobe.
  always @(posedge sysClk) if (sysRdEn) sysRdData <= memf(sysAddr);

  always @(negedge sysClk) begin
    wrRun = sysWrEn ? wrRun + 1 : 0;
    rdRun = sysRdEn ? rdRun + 1 : 0;
    if (wrRun > maxRun) maxRun = wrRun;
    if (rdRun > maxRun) maxRun = rdRun;
    if (sysWrEn && wrRun == 1) begin
      wrCnt++; lastWrAddr = sysAddr; lastWrData = sysWrData;
    end
    if (sysRdEn && rdRun == 1) begin
      rdCnt++; lastRdAddr = sysAddr;
    end
  end

  always @(negedge hostClk) if (hostAck) ackTotal++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitAck(output bit got);
    got = 0;
    for (int i = 0; i < 3000 && !got; i++) begin
      if (hostAck) got = 1;
      else @(negedge hostClk);
    end
  endtask

  task automatic runTxn(input logic [47:0] p, output bit got);
    @(negedge hostClk);
    hostReq = 1'b1; hostPayload = p;
    @(negedge hostClk);
    hostReq = 1'b0; hostPayload = ~p;   // R5: scrambled after capture
    waitAck(got);
    @(negedge hostClk);
    chk("R4 ack one cycle", {63'd0, hostAck}, 64'd0);
  endtask

  localparam logic [47:0] VEC [6] = '{
    {2'b10, 14'h0001, 32'hDEAD_BEEF},
    {2'b01, 14'h0001, 32'h1234_5678},
    {2'b10, 14'h3FFF, 32'hFFFF_0000},
    {2'b01, 14'h3FFF, 32'h0000_0000},
    {2'b10, 14'h0000, 32'h0000_FFFF},
    {2'b01, 14'h2AAA, 32'hCAFE_F00D}
  };

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit got;
    int w0, r0, a0;
    logic [31:0] wd0, resp0;
    repeat (5) @(negedge hostClk);
    // R10 reset values
    chk("R10 hostAck", {63'd0, hostAck}, 64'd0);
    chk("R10 hostResp", {32'd0, hostResp}, 64'd0);
    chk("R10 sysWrEn", {63'd0, sysWrEn}, 64'd0);
    chk("R10 sysRdEn", {63'd0, sysRdEn}, 64'd0);
    chk("R10 sysAddr", {50'd0, sysAddr}, 64'd0);
    chk("R10 sysWrData", {32'd0, sysWrData}, 64'd0);
    hostRstN = 1'b1; sysRstN = 1'b1;
    repeat (3) @(negedge hostClk);

    // Vector walk: R1, R2, R5, R7
    for (int v = 0; v < 6; v++) begin
      w0 = wrCnt; r0 = rdCnt; wd0 = sysWrData;
      runTxn(VEC[v], got);
      chk("R9 ack arrives", {63'd0, got}, 64'd1);
      if (VEC[v][47]) begin
        chk("R1 write count", 64'(wrCnt), 64'(w0 + 1));
        chk("R1 write addr", {50'd0, lastWrAddr}, {50'd0, VEC[v][45:32]});
        chk("R1 write data", {32'd0, lastWrData}, {32'd0, VEC[v][31:0]});
        chk("R5 no read on write", 64'(rdCnt), 64'(r0));
      end else begin
        chk("R2 read count", 64'(rdCnt), 64'(r0 + 1));
        chk("R2 read addr", {50'd0, lastRdAddr}, {50'd0, VEC[v][45:32]});
        chk("R2 read resp", {32'd0, hostResp}, {32'd0, memf(VEC[v][45:32])});
        chk("R7 wrdata kept", {32'd0, sysWrData}, {32'd0, wd0});
      end
    end

    // R4: response held after ack
    resp0 = hostResp;
    repeat (20) @(negedge hostClk);
    chk("R4 resp held", {32'd0, hostResp}, {32'd0, resp0});

    // R6: second request while busy is dropped
    w0 = wrCnt; r0 = rdCnt; a0 = ackTotal;
    @(negedge hostClk);
    hostReq = 1'b1; hostPayload = {2'b01, 14'h0123, 32'h0};
    @(negedge hostClk);
    hostReq = 1'b0;
    @(negedge hostClk);
    hostReq = 1'b1; hostPayload = {2'b10, 14'h0456, 32'hBAD0_BAD0};
    @(negedge hostClk);
    hostReq = 1'b0; hostPayload = '0;
    waitAck(got);
    chk("R6 resp of first", {32'd0, hostResp}, {32'd0, memf(14'h0123)});
    repeat (100) @(negedge hostClk);
    chk("R6 one ack", 64'(ackTotal), 64'(a0 + 1));
    chk("R6 no write", 64'(wrCnt), 64'(w0));
    chk("R6 one read", 64'(rdCnt), 64'(r0 + 1));
    chk("R6 addr kept", {50'd0, sysAddr}, {50'd0, 14'h0123});

    // R8: both flags -> write only; neither -> ack, no strobe
    w0 = wrCnt; r0 = rdCnt;
    runTxn({2'b11, 14'h0777, 32'h55AA_55AA}, got);
    chk("R8 both: write", 64'(wrCnt), 64'(w0 + 1));
    chk("R8 both: no read", 64'(rdCnt), 64'(r0));
    chk("R8 both: data", {32'd0, lastWrData}, 64'h55AA_55AA);
    w0 = wrCnt; r0 = rdCnt;
    runTxn({2'b00, 14'h0999, 32'h1111_2222}, got);
    chk("R8 none: ack", {63'd0, got}, 64'd1);
    chk("R8 none: strobes", 64'(wrCnt + rdCnt), 64'(w0 + r0));

    // R9: stall the system clock, request must survive
    a0 = ackTotal; r0 = rdCnt;
    @(negedge sysClk);
    sysClkEn = 1'b0;
    @(negedge hostClk);
    hostReq = 1'b1; hostPayload = {2'b01, 14'h1357, 32'h0};
    @(negedge hostClk);
    hostReq = 1'b0; hostPayload = '1;
    repeat (300) @(negedge hostClk);
    chk("R9 no ack while stalled", 64'(ackTotal), 64'(a0));
    sysClkEn = 1'b1;
    waitAck(got);
    chk("R9 ack after resume", {63'd0, got}, 64'd1);
    chk("R9 resp", {32'd0, hostResp}, {32'd0, memf(14'h1357)});
    chk("R9 one read", 64'(rdCnt), 64'(r0 + 1));

    repeat (5) @(negedge hostClk);
    chk("R3 strobe width", 64'(maxRun), 64'd1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule